// File: doc/BRIEF.md
# Prime Number Supply Pipeline

This block supplies small prime numbers on demand to an RSA key generator that needs a 16-bit modulus. A linear feedback shift register makes odd 8-bit candidates and loads them into a candidate queue. A trial-division tester takes candidates from that queue one at a time. It writes the ones it proves prime into an output queue and drops the composites.

Each stage works only while the queue in front of it has room. When nobody drains the output, the generator and the tester both come to a halt and stop toggling, and no candidate is lost. A consumer reads primes from the head of the output queue, normally two per key pair. Because each prime is below 256, the product of any two of them fits in 16 bits.

Top module: `prime_supply`

## Requirements
- R1: After reset the output queue is empty: `empty_o` is 1 and `full_o` is 0.
- R2: The generator is a 16-bit Fibonacci LFSR loaded with `SEED` (default 16'hACE1). Each step shifts left by one, and the new bit 0 is the XOR of state bits 15, 14, 12 and 3. A candidate is the low 8 state bits with bit 0 forced to 1, and the value 1 is replaced by 3. The first candidate comes from the seed itself.
- R3: The generator writes one candidate and steps its LFSR on every cycle in which the candidate queue is not full. While that queue is full it holds its state, so no candidate is skipped or repeated.
- R4: The tester takes a new candidate only when the candidate queue is non-empty and the output queue is not full.
- R5: Only candidates found prime reach the output queue, and composites are dropped. The primes come out in the same order as their candidates were generated.
- R6: A candidate n is prime when no odd divisor d, with d starting at 3 and d*d <= n, divides it exactly. The remainder is formed by subtracting d once per cycle.
- R7: The output queue holds 4 primes. `full_o` rises after four primes are stored with no reads, and the block then does no further work until a read is made.
- R8: The head prime is shown on `prime_o` whenever `empty_o` is 0. A cycle with `pop_i` high removes it. A `pop_i` while the queue is empty is ignored.
- R9: A write to a full queue never happens, and a read never takes an entry from an empty queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pop_i | input | 1 | Remove the head prime |
| prime_o | output | 8 | Head prime, valid while empty_o is 0 |
| empty_o | output | 1 | Output queue holds no prime |
| full_o | output | 1 | Output queue holds 4 primes |

## Verification
The assertions assume only that `pop_i` is a clean synchronous level and that reset is applied at the start. They do not assume the consumer reads only when data is present, because reads into an empty queue must be ignored. The stimulus deliberately raises `pop_i` while the queue is empty, and it keeps `pop_i` low for long stretches so that both queues fill and the stall paths are used. Everywhere else it reads only while `empty_o` is low and changes `pop_i` on the falling clock edge.

// File: rtl/prime_pipe_pkg.sv
package prime_pipe_pkg;
  localparam int unsigned CAND_W  = 8;
  localparam int unsigned LFSR_W  = 16;
  localparam int unsigned Q_DEPTH = 4;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  typedef enum logic {TST_IDLE, TST_RUN} tst_state_e;
endpackage

// File: rtl/prime_pipe_fifo.sv
module prime_pipe_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/prime_pipe_gen.sv
module prime_pipe_gen #(
  parameter int unsigned          LFSR_W = 16,
  parameter int unsigned          CAND_W = 8,
  parameter logic [LFSR_W-1:0]    TAPS   = 16'hD008,
  parameter logic [LFSR_W-1:0]    SEED   = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              full_i,
  output logic              push_o,
  output logic [CAND_W-1:0] cand_o,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q;
  logic [CAND_W-1:0] odd_v;

  assign push_o  = !full_i;
  assign odd_v   = state_q[CAND_W-1:0] | CAND_W'(1);
  assign cand_o  = (odd_v == CAND_W'(1)) ? CAND_W'(3) : odd_v;
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (push_o) state_q <= {state_q[LFSR_W-2:0], ^(state_q & TAPS)};
  end
endmodule

// File: rtl/prime_pipe_tester.sv
module prime_pipe_tester
  import prime_pipe_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cand_empty_i,
  input  logic [W-1:0] cand_i,
  input  logic         prime_full_i,
  output logic         cand_pop_o,
  output logic         prime_push_o,
  output logic [W-1:0] prime_o
);
  tst_state_e   st_q;
  logic [W-1:0] n_q, div_q, rem_q;
  logic [2*W-1:0] sq;
  logic         div_done;

  assign sq       = {{W{1'b0}}, div_q} * {{W{1'b0}}, div_q};
  assign div_done = sq > {{W{1'b0}}, n_q};
  assign cand_pop_o   = (st_q == TST_IDLE) && !cand_empty_i && !prime_full_i;
  assign prime_push_o = (st_q == TST_RUN) && div_done;
  assign prime_o      = n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TST_IDLE;
      n_q   <= '0;
      div_q <= '0;
      rem_q <= '0;
    end else begin
      unique case (st_q)
        TST_IDLE: if (cand_pop_o) begin
          n_q   <= cand_i;
          rem_q <= cand_i;
          div_q <= W'(3);
          st_q  <= TST_RUN;
        end
        TST_RUN: begin
          if (div_done)             st_q  <= TST_IDLE;
          else if (rem_q >= div_q)  rem_q <= rem_q - div_q;
          else if (rem_q == '0)     st_q  <= TST_IDLE;  // composite, drop
          else begin
            div_q <= div_q + W'(2);
            rem_q <= n_q;
          end
        end
        default: st_q <= TST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prime_supply.sv
module prime_supply
  import prime_pipe_pkg::*;
#(
  parameter int unsigned       W     = CAND_W,
  parameter int unsigned       DEPTH = Q_DEPTH,
  parameter logic [LFSR_W-1:0] SEED  = LFSR_SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pop_i,
  output logic [W-1:0] prime_o,
  output logic         empty_o,
  output logic         full_o
);
  logic              cand_push, cand_pop, cand_full, cand_empty;
  logic [W-1:0]      cand_din, cand_dout, prime_din;
  logic              prime_push;
  logic [LFSR_W-1:0] lfsr_state;

  prime_pipe_gen #(.LFSR_W(LFSR_W), .CAND_W(W), .TAPS(LFSR_TAPS), .SEED(SEED)) u_gen (
    .clk_i, .rst_ni, .full_i(cand_full), .push_o(cand_push),
    .cand_o(cand_din), .state_o(lfsr_state)
  );

  prime_pipe_fifo #(.W(W), .DEPTH(DEPTH)) u_cand_q (
    .clk_i, .rst_ni, .push_i(cand_push), .din_i(cand_din), .pop_i(cand_pop),
    .dout_o(cand_dout), .full_o(cand_full), .empty_o(cand_empty)
  );

  prime_pipe_tester #(.W(W)) u_tester (
    .clk_i, .rst_ni, .cand_empty_i(cand_empty), .cand_i(cand_dout),
    .prime_full_i(full_o), .cand_pop_o(cand_pop), .prime_push_o(prime_push),
    .prime_o(prime_din)
  );

  prime_pipe_fifo #(.W(W), .DEPTH(DEPTH)) u_prime_q (
    .clk_i, .rst_ni, .push_i(prime_push), .din_i(prime_din), .pop_i(pop_i),
    .dout_o(prime_o), .full_o(full_o), .empty_o(empty_o)
  );
endmodule

// File: rtl/prime_supply_chk.sv
module prime_supply_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned LW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cand_push,
  input logic          cand_pop,
  input logic          cand_full,
  input logic          cand_empty,
  input logic          prime_push,
  input logic [W-1:0]  prime_din,
  input logic          prime_full,
  input logic          prime_empty,
  input logic [LW-1:0] lfsr_state
);
  AST_CAND_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_full |-> !cand_push); // R9
  AST_PRIME_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) prime_full |-> !prime_push); // R9
  AST_CAND_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_pop |-> !cand_empty); // R9
  AST_GEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_full |=> $stable(lfsr_state)); // R3
  AST_TEST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) cand_pop |-> !prime_full); // R4
  AST_PRIME_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni) prime_push |-> (prime_din[0] && prime_din >= W'(3))); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(prime_full && prime_empty)); // R7
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni) (prime_full && cand_full) |=> $stable(lfsr_state)); // R7
endmodule

bind prime_supply prime_supply_chk #(.W(W), .LW(prime_pipe_pkg::LFSR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cand_push(cand_push), .cand_pop(cand_pop),
  .cand_full(cand_full), .cand_empty(cand_empty), .prime_push(prime_push),
  .prime_din(prime_din), .prime_full(full_o), .prime_empty(empty_o),
  .lfsr_state(lfsr_state)
);

// File: tb/prime_supply_tb.sv
module prime_supply_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pop_i = 1'b0;
  logic [7:0] prime_o;
  logic       empty_o, full_o;
  int         n_chk = 0, n_fail = 0;
  logic [15:0] m_state = 16'hACE1;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  prime_supply u_dut (.clk_i, .rst_ni, .pop_i, .prime_o, .empty_o, .full_o);

  function automatic bit is_prime(input int v);
    if (v < 2) return 1'b0;
    for (int d = 2; d * d <= v; d++) if (v % d == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] cand_of(input logic [15:0] s);
    logic [7:0] v;
    v = s[7:0] | 8'd1;
    return (v == 8'd1) ? 8'd3 : v;
  endfunction

  // Next prime expected from the R2 candidate sequence
  function automatic logic [7:0] next_exp();
    logic [7:0] c;
    forever begin
      c = cand_of(m_state);
      m_state = {m_state[14:0], m_state[15] ^ m_state[14] ^ m_state[12] ^ m_state[3]};
      if (is_prime(int'(c))) return c;
    end
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pop_one(input string req);
    logic [7:0] e;
    while (empty_o) @(negedge clk_i);
    e = next_exp();
    check(req, int'(prime_o), int'(e));
    check({req, " primality"}, int'(is_prime(int'(prime_o))), 1);
    pop_i = 1'b1;
    @(negedge clk_i);
    pop_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 empty_o", int'(empty_o), 1);
    check("R1 full_o", int'(full_o), 0);
  endtask

  task automatic t_pop_empty();
    // R8: pop while empty must be ignored
    check("R8 empty before pop", int'(empty_o), 1);
    pop_i = 1'b1;
    @(negedge clk_i);
    pop_i = 1'b0;
    pop_one("R8 first prime after empty pop");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 20; i++) pop_one("R5 R6 streamed prime");
  endtask

  task automatic t_backpressure();
    repeat (5000) @(negedge clk_i);
    check("R7 full after idle", int'(full_o), 1);
    check("R7 not empty", int'(empty_o), 0);
    repeat (500) @(negedge clk_i);
    check("R7 still full", int'(full_o), 1);
    for (int i = 0; i < 4; i++) pop_one("R3 R4 prime after stall");
    for (int i = 0; i < 8; i++) pop_one("R2 R3 prime after resume");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pop_empty();
    t_stream();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule